// File: doc/BRIEF.md
# One-Time-Programmable Fuse Read Controller

This block lets a host read a 512-byte one-time-programmable fuse array through a small 32-bit register bus. Software first clears the power-down bit and sets the read-enable bit. It then loads a word address, and pulses an address-latch bit and then a start bit, each written as set followed by clear. It polls a busy flag and, once that flag drops, fetches the word from a data register. The word is either one byte or four bytes wide, chosen by a parameter. The word address is the byte offset divided by the word width.

The fuse array is modelled as a bank of byte registers that a test port can preload. A fixed, parameterised number of cycles stands in for the sense timing of a real array. The control bits for fuse programming and for encryption are stored and read back, but they start no operation.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset, offset 0x04 reads 0x0800_0000 (power-down, bit 27, is 1), offset 0x08 reads 0 and offset 0x10 reads 0.
- R2: Offset 0x04 stores bits 27, 25, 24, 23:16, 13, 12, 11 and 10:0 and returns them on read. Bits 31:28, 26, 15 and 14 read 0, and writes to them have no effect; bit 26 is the read-only busy flag.
- R3: The word address in bits 10:0 becomes the read target only on a write that moves bit 11 from 0 to 1. A later write that changes bits 10:0 without such a rise does not change which word a later start fetches.
- R4: A write that moves bit 25 from 0 to 1 starts a read when the same written word has bit 27 = 0 and bit 24 = 1 and no read is running. Busy (bit 26 of offset 0x04) is then 1 from the next cycle for exactly READ_LAT cycles, so the first read after the clearing write already sees 1.
- R5: Once busy drops, offset 0x08 holds the fetched word: byte (target × WORD_BYTES + k) sits in bits 8k+7:8k. With WORD_BYTES = 1, bits 31:8 read 0.
- R6: A start rise is refused when the written word has bit 27 = 1 or bit 24 = 0. Busy stays 0 and offset 0x08 keeps its value.
- R7: While busy, start rises are ignored and a new address latch does not alter the running read's address or length. The latched address is used by the next accepted start.
- R8: A target whose byte offset (target × WORD_BYTES) is 512 or more completes with the normal busy length and returns 0.
- R9: Offsets other than 0x04, 0x08 and 0x10 read 0 and ignore writes. Offset 0x08 ignores writes. Read data is 0 while the read strobe is low.
- R10: Offset 0x10 stores only bit 10 (encryption enable); its other bits read 0.
- R11: A preload-port write places the byte in the array at once, and the last word of the array and word 0 are returned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| pre_we | input | 1 | Test preload write enable |
| pre_addr | input | 9 | Test preload byte address |
| pre_data | input | 8 | Test preload byte |

## Verification
The bench builds two copies of the block side by side, one with four-byte words and one with single-byte words, both with a read latency of 8. They share one preloaded array image. The four-byte copy covers little-endian lane packing, the last word at target 127 and out-of-range targets past it. The single-byte copy covers zeroed upper lanes, the last byte at 511, and targets from 512 up to the top of the 11-bit field. A latency of 8 leaves enough busy cycles to issue a second latch and start inside a running read.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;

  localparam int BUS_AW  = 5;
  localparam int DATA_W  = 32;
  localparam int WADDR_W = 11;

  localparam logic [BUS_AW-1:0] OFS_CTL1 = 5'h04;
  localparam logic [BUS_AW-1:0] OFS_DATA = 5'h08;
  localparam logic [BUS_AW-1:0] OFS_CTL4 = 5'h10;

  localparam int B_PD    = 27;
  localparam int B_BUSY  = 26;
  localparam int B_START = 25;
  localparam int B_EN    = 24;
  localparam int B_SET   = 11;

  // bits kept in the control words; the rest read back as zero
  localparam logic [DATA_W-1:0] CTL1_KEEP  = 32'h0BFF_3FFF;
  localparam logic [DATA_W-1:0] CTL1_RESET = 32'h0800_0000;
  localparam logic [DATA_W-1:0] CTL4_KEEP  = 32'h0000_0400;

endpackage

// File: rtl/efuse_fuse_bank.sv
module efuse_fuse_bank
  import efuse_rd_pkg::*;
#(
  parameter int ARRAY_BYTES = 512,
  parameter int WORD_BYTES  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pre_we,
  input  logic [$clog2(ARRAY_BYTES)-1:0] pre_addr,
  input  logic [7:0]                     pre_data,
  input  logic [WADDR_W-1:0]             word_addr,
  output logic [DATA_W-1:0]              word_data
);

  localparam int BA_W  = $clog2(ARRAY_BYTES);
  localparam int IDX_W = WADDR_W + 3;
  localparam int LANES = DATA_W / 8;

  logic [7:0] fuse_q [ARRAY_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARRAY_BYTES; i++) fuse_q[i] <= '0;
    end else if (pre_we) begin
      fuse_q[pre_addr] <= pre_data;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < WORD_BYTES) begin : g_live
      logic [IDX_W-1:0] idx;
      always_comb begin
        idx = IDX_W'(word_addr) * IDX_W'(WORD_BYTES) + IDX_W'(l);
        if (idx < IDX_W'(ARRAY_BYTES)) word_data[8*l +: 8] = fuse_q[idx[BA_W-1:0]];
        else                           word_data[8*l +: 8] = 8'h00;
      end
    end else begin : g_dead
      assign word_data[8*l +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/efuse_rd_regs.sv
module efuse_rd_regs
  import efuse_rd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  input  logic               busy_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               start_req_o,
  output logic [WADDR_W-1:0] target_o,
  output logic               start_bit_q_o
);

  logic [DATA_W-1:0]  ctl1_q, ctl1_d;
  logic [DATA_W-1:0]  ctl4_q, ctl4_d;
  logic [WADDR_W-1:0] tgt_q, tgt_d;
  logic               ctl1_en, ctl4_en, tgt_en;
  logic               set_rise, start_rise;

  // next-state
  always_comb begin
    ctl1_en    = bus_wr && (bus_addr == OFS_CTL1);
    ctl4_en    = bus_wr && (bus_addr == OFS_CTL4);
    ctl1_d     = bus_wdata & CTL1_KEEP;
    ctl4_d     = bus_wdata & CTL4_KEEP;
    set_rise   = ctl1_en && bus_wdata[B_SET]   && !ctl1_q[B_SET];
    start_rise = ctl1_en && bus_wdata[B_START] && !ctl1_q[B_START];
    tgt_en     = set_rise;
    tgt_d      = bus_wdata[WADDR_W-1:0];
    start_req_o = start_rise && !bus_wdata[B_PD] && bus_wdata[B_EN];
    target_o    = tgt_en ? tgt_d : tgt_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= CTL1_RESET;
      ctl4_q <= '0;
      tgt_q  <= '0;
    end else begin
      if (ctl1_en) ctl1_q <= ctl1_d;
      if (ctl4_en) ctl4_q <= ctl4_d;
      if (tgt_en)  tgt_q  <= tgt_d;
    end
  end

  assign start_bit_q_o = ctl1_q[B_START];

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_CTL1: begin
          bus_rdata         = ctl1_q;
          bus_rdata[B_BUSY] = busy_i;
        end
        OFS_DATA: bus_rdata = data_i;
        OFS_CTL4: bus_rdata = ctl4_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/efuse_rd_seq.sv
module efuse_rd_seq
  import efuse_rd_pkg::*;
#(
  parameter int READ_LAT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic [WADDR_W-1:0] target,
  input  logic [DATA_W-1:0]  fetch_word,
  output logic [WADDR_W-1:0] fetch_addr,
  output logic               busy_o,
  output logic [DATA_W-1:0]  data_o
);

  localparam int CNT_W = (READ_LAT < 2) ? 1 : $clog2(READ_LAT);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(READ_LAT - 1);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [WADDR_W-1:0] act_q, act_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               act_en, data_en;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    act_d   = target;
    act_en  = 1'b0;
    data_d  = fetch_word;
    data_en = 1'b0;
    if (!busy_q) begin
      if (start_req) begin
        busy_d = 1'b1;
        cnt_d  = CNT_LOAD;
        act_en = 1'b1;
      end
    end else if (cnt_q == '0) begin
      busy_d  = 1'b0;
      data_en = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      act_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (act_en)  act_q  <= act_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign fetch_addr = act_q;
  assign busy_o     = busy_q;
  assign data_o     = data_q;

endmodule

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl
  import efuse_rd_pkg::*;
#(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512,
  parameter int READ_LAT    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [BUS_AW-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_rd,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic                           pre_we,
  input  logic [$clog2(ARRAY_BYTES)-1:0] pre_addr,
  input  logic [7:0]                     pre_data
);

  logic               rd_busy;
  logic [DATA_W-1:0]  rd_data;
  logic               start_req;
  logic [WADDR_W-1:0] target;
  logic               start_bit_q;
  logic [WADDR_W-1:0] fetch_addr;
  logic [DATA_W-1:0]  fetch_word;

  efuse_rd_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rd        (bus_rd),
    .busy_i        (rd_busy),
    .data_i        (rd_data),
    .bus_rdata     (bus_rdata),
    .start_req_o   (start_req),
    .target_o      (target),
    .start_bit_q_o (start_bit_q)
  );

  efuse_rd_seq #(.READ_LAT(READ_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .target     (target),
    .fetch_word (fetch_word),
    .fetch_addr (fetch_addr),
    .busy_o     (rd_busy),
    .data_o     (rd_data)
  );

  efuse_fuse_bank #(.ARRAY_BYTES(ARRAY_BYTES), .WORD_BYTES(WORD_BYTES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_we    (pre_we),
    .pre_addr  (pre_addr),
    .pre_data  (pre_data),
    .word_addr (fetch_addr),
    .word_data (fetch_word)
  );

endmodule

// File: rtl/efuse_rd_chk.sv
module efuse_rd_chk
  import efuse_rd_pkg::*;
#(
  parameter int READ_LAT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              wd_pd,
  input logic              wd_start,
  input logic              wd_en,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              start_q,
  input logic              busy,
  input logic [DATA_W-1:0] data_q
);

  logic [31:0] len_q;
  logic        start_rise;
  logic        unused_ofs;

  assign start_rise = bus_wr && (bus_addr == OFS_CTL1) && wd_start && !start_q && !busy;
  assign unused_ofs = (bus_addr != OFS_CTL1) && (bus_addr != OFS_DATA) && (bus_addr != OFS_CTL4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 1'b1;
    else           len_q <= '0;
  end

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !wd_pd && wd_en) |=> busy);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == 32'(READ_LAT)));

  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && (wd_pd || !wd_en)) |=> !busy);

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $fell(busy));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd && unused_ofs) || !bus_rd) |-> (bus_rdata == '0));

endmodule

bind efuse_rd_ctrl efuse_rd_chk #(.READ_LAT(READ_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .wd_pd     (bus_wdata[27]),
  .wd_start  (bus_wdata[25]),
  .wd_en     (bus_wdata[24]),
  .bus_rdata (bus_rdata),
  .start_q   (start_bit_q),
  .busy      (rd_busy),
  .data_q    (rd_data)
);

// File: tb/test_efuse_rd_ctrl.sv
module test_efuse_rd_ctrl;

  localparam int LAT = 8;
  localparam logic [4:0] A_CTL1 = 5'h04;
  localparam logic [4:0] A_DATA = 5'h08;
  localparam logic [4:0] A_CTL4 = 5'h10;
  localparam logic [31:0] M_PD    = 32'h0800_0000;
  localparam logic [31:0] M_BUSY  = 32'h0400_0000;
  localparam logic [31:0] M_START = 32'h0200_0000;
  localparam logic [31:0] M_EN    = 32'h0100_0000;
  localparam logic [31:0] M_SET   = 32'h0000_0800;

  logic        clk;
  logic        rst_n;
  logic [4:0]  ba  [2];
  logic        bw  [2];
  logic        br  [2];
  logic [31:0] bwd [2];
  logic [31:0] brd [2];
  logic        pre_we;
  logic [8:0]  pre_addr;
  logic [7:0]  pre_data;
  logic [7:0]  model [512];
  int          n_chk;
  int          n_fail;
  bit          done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  efuse_rd_ctrl #(.WORD_BYTES(4), .READ_LAT(LAT)) i_efuse_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(ba[0]), .bus_wr(bw[0]), .bus_wdata(bwd[0]),
    .bus_rd(br[0]), .bus_rdata(brd[0]), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data));

  efuse_rd_ctrl #(.WORD_BYTES(1), .READ_LAT(LAT)) i_efuse_rd_ctrl_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(ba[1]), .bus_wr(bw[1]), .bus_wdata(bwd[1]),
    .bus_rd(br[1]), .bus_rdata(brd[1]), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data));

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 7) ^ (i >> 2));
  endfunction

  function automatic logic [31:0] exp_word(int u, int a);
    logic [31:0] w = '0;
    int wb = (u == 0) ? 4 : 1;
    for (int k = 0; k < wb; k++)
      if (a * wb + k < 512) w[8*k +: 8] = model[a * wb + k];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(int u, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    ba[u] = a; bwd[u] = d; bw[u] = 1'b1;
    @(posedge clk);
    #1 bw[u] = 1'b0;
  endtask

  task automatic rd(int u, logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    ba[u] = a; br[u] = 1'b1;
    #1 d = brd[u];
    @(posedge clk);
    #1 br[u] = 1'b0;
  endtask

  task automatic preload(int i, logic [7:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = 9'(i); pre_data = v;
    model[i] = v;
    @(posedge clk);
    #1 pre_we = 1'b0;
  endtask

  // start with the current field value, then poll busy; returns busy reads seen
  task automatic start_poll(int u, logic [31:0] base, output int nbusy);
    logic [31:0] v;
    wr(u, A_CTL1, base | M_START);
    wr(u, A_CTL1, base);
    nbusy = 0;
    for (int i = 0; i < 64; i++) begin
      rd(u, A_CTL1, v);
      if (v[26]) nbusy++;
      else break;
    end
  endtask

  task automatic do_read(int u, int a, output logic [31:0] d, output int nbusy);
    logic [31:0] base = M_EN | 32'(a[10:0]);
    wr(u, A_CTL1, base | M_SET);
    wr(u, A_CTL1, base);
    start_poll(u, base, nbusy);
    rd(u, A_DATA, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int u = 0; u < 2; u++) begin
      rd(u, A_CTL1, v); check("R1 ctl1 reset", v, 32'h0800_0000);
      rd(u, A_DATA, v); check("R1 data reset", v, 32'h0);
      rd(u, A_CTL4, v); check("R1 ctl4 reset", v, 32'h0);
    end
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(0, A_CTL1, 32'hFFFF_FFFF);
    rd(0, A_CTL1, v); check("R2 ctl1 readback, busy bit read-only", v, 32'h0BFF_3FFF);
    wr(0, A_CTL1, 32'h0);
    rd(0, A_CTL1, v); check("R2 ctl1 cleared", v, 32'h0);
    wr(0, A_CTL4, 32'hFFFF_FFFF);
    rd(0, A_CTL4, v); check("R10 ctl4 only bit10", v, 32'h0000_0400);
    wr(0, A_CTL4, 32'h0);
    rd(0, A_CTL4, v); check("R10 ctl4 cleared", v, 32'h0);
    wr(0, 5'h00, 32'hFFFF_FFFF);
    wr(0, 5'h0C, 32'hFFFF_FFFF);
    wr(0, 5'h1C, 32'hFFFF_FFFF);
    wr(0, A_DATA, 32'hFFFF_FFFF);
    rd(0, 5'h00, v); check("R9 offset 0x00 zero", v, 32'h0);
    rd(0, 5'h0C, v); check("R9 offset 0x0C zero", v, 32'h0);
    rd(0, 5'h1C, v); check("R9 offset 0x1C zero", v, 32'h0);
    rd(0, A_DATA, v); check("R9 data ignores writes", v, 32'h0);
    rd(0, A_CTL1, v); check("R9 ctl1 unchanged by other writes", v, 32'h0);
    @(negedge clk); ba[0] = A_CTL1; #1;
    check("R9 read data zero without strobe", brd[0], 32'h0);
  endtask

  task automatic t_words();
    logic [31:0] d;
    int nb;
    int al[4] = '{0, 1, 64, 77};
    foreach (al[i]) begin
      do_read(0, al[i], d, nb); check("R5 wide word packing", d, exp_word(0, al[i]));
      do_read(1, al[i], d, nb); check("R5 byte word upper zero", d, exp_word(1, al[i]));
    end
  endtask

  task automatic t_latch();
    logic [31:0] d;
    int nb;
    do_read(0, 5, d, nb); check("R3 first latched word", d, exp_word(0, 5));
    wr(0, A_CTL1, M_EN | 32'd9);
    start_poll(0, M_EN | 32'd9, nb);
    rd(0, A_DATA, d); check("R3 field change without latch ignored", d, exp_word(0, 5));
  endtask

  task automatic t_busy();
    logic [31:0] d;
    int nb;
    do_read(0, 33, d, nb);
    check("R4 busy reads after start clear", 32'(nb), 32'(LAT - 1));
    do_read(1, 33, d, nb);
    check("R4 busy reads byte unit", 32'(nb), 32'(LAT - 1));
  endtask

  task automatic t_refuse();
    logic [31:0] d0, v;
    int nb;
    do_read(0, 3, d0, nb);
    wr(0, A_CTL1, M_PD | M_EN | 32'd6 | M_SET);
    wr(0, A_CTL1, M_PD | M_EN | 32'd6);
    wr(0, A_CTL1, M_PD | M_EN | 32'd6 | M_START);
    rd(0, A_CTL1, v); check("R6 no busy while powered down", v & M_BUSY, 32'h0);
    wr(0, A_CTL1, M_PD | M_EN | 32'd6);
    repeat (LAT + 2) rd(0, A_CTL1, v);
    rd(0, A_DATA, v); check("R6 data kept while powered down", v, d0);
    wr(0, A_CTL1, 32'd6 | M_START);
    rd(0, A_CTL1, v); check("R6 no busy while read disabled", v & M_BUSY, 32'h0);
    wr(0, A_CTL1, 32'd6);
    repeat (LAT + 2) rd(0, A_CTL1, v);
    rd(0, A_DATA, v); check("R6 data kept while read disabled", v, d0);
  endtask

  task automatic t_overlap();
    logic [31:0] d, v;
    int nb;
    logic [31:0] b1 = M_EN | 32'd10;
    logic [31:0] b2 = M_EN | 32'd20;
    wr(0, A_CTL1, b1 | M_SET);
    wr(0, A_CTL1, b1);
    wr(0, A_CTL1, b1 | M_START);
    wr(0, A_CTL1, b1);
    wr(0, A_CTL1, b2 | M_SET);
    wr(0, A_CTL1, b2);
    wr(0, A_CTL1, b2 | M_START);
    wr(0, A_CTL1, b2);
    nb = 0;
    for (int i = 0; i < 64; i++) begin
      rd(0, A_CTL1, v);
      if (v[26]) nb++;
      else break;
    end
    check("R7 running read keeps its length", 32'(nb), 32'(LAT - 5));
    rd(0, A_DATA, d); check("R7 running read keeps its address", d, exp_word(0, 10));
    start_poll(0, b2, nb);
    rd(0, A_DATA, d); check("R7 address latched during busy used next", d, exp_word(0, 20));
  endtask

  task automatic t_range();
    logic [31:0] d;
    int nb;
    do_read(0, 127, d, nb); check("R11 last wide word", d, exp_word(0, 127));
    do_read(1, 511, d, nb); check("R11 last byte", d, exp_word(1, 511));
    do_read(0, 128, d, nb); check("R8 wide word past end is zero", d, 32'h0);
    check("R8 wide past end normal busy", 32'(nb), 32'(LAT - 1));
    do_read(0, 200, d, nb); check("R8 wide word 200 is zero", d, 32'h0);
    do_read(1, 512, d, nb); check("R8 byte 512 is zero", d, 32'h0);
    do_read(1, 2047, d, nb); check("R8 byte 2047 is zero", d, 32'h0);
    check("R8 byte past end normal busy", 32'(nb), 32'(LAT - 1));
    preload(511, 8'hA5);
    preload(0, 8'h3C);
    do_read(1, 511, d, nb); check("R11 preload reaches last byte", d, 32'h0000_00A5);
    do_read(0, 0, d, nb); check("R11 preload reaches word 0", d, exp_word(0, 0));
  endtask

  initial begin
    int fin;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    for (int u = 0; u < 2; u++) begin
      ba[u] = '0; bw[u] = 1'b0; br[u] = 1'b0; bwd[u] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int i = 0; i < 512; i++) preload(i, pat(i));
    t_fields();
    t_words();
    t_latch();
    t_busy();
    t_refuse();
    t_overlap();
    t_range();
    fin = 1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule